// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device-side half of a receive DMA path. It accepts Ethernet frame bytes as a byte stream with start and end markers. It spreads each frame over a circular ring of fixed 128-byte buffers. Every ring entry has a two-word descriptor. The first word gives the buffer's byte offset, the last-entry (wrap) flag and an ownership flag. The second word carries the status. Frame bytes leave the block through a byte-wide write port into an external buffer memory, at byte address `entry * 128 + offset`.

When a buffer is full, or the frame ends, the block writes that entry's status word. One cycle later it sets the entry's ownership ("used") bit and moves to the next entry. After the last entry it moves back to entry 0. A frame can therefore continue past the end of the ring into entry 0.

Software is modelled by two simple ports. One reads both words of any descriptor one cycle after the index is presented. The other clears an entry's used bit to hand the buffer back. When the block needs a buffer that software has not yet returned, it discards the remainder of that frame and pulses an overrun output.

Top module: `rxr_ring_writer`

## Requirements
- R1: After synchronous reset, `buf_we`, `overrun`, `sw_word0` and `sw_word1` are 0, the ring position is entry 0, and every entry's used bit is clear.
- R2: The bytes of a frame appear on the write port, registered one cycle after they are accepted, at consecutive addresses `entry*128 + offset`. The first byte of a frame goes to offset 0 of the current entry.
- R3: After offset 127 of an entry is written, or after the end byte, the next buffer is the following entry. Entry RING-1 is followed by entry 0, so a frame may continue from the last entry into entry 0.
- R4: Descriptor word 0 reads as `entry*128` in bits [IW+6:7], bit 1 = 1 only for entry RING-1, and bit 0 = used.
- R5: A filled entry's word 1 is stored one cycle before its used bit is set. A reader watching one entry never sees used rise before the final status.
- R6: Word 1 has these fields. Bit 14 is set in the buffer holding a frame's first byte. Bit 15 is set in the buffer holding its last byte. Bits 11:0 hold the total frame length (modulo 4096) in the end buffer only, and are 0 in every other buffer.
- R7: Bit 31 of word 1 is set in the end buffer when the frame is at least 6 bytes long and its first 6 bytes are all 0xFF. Otherwise it is 0.
- R8: When a buffer is needed and the current entry's used bit is set, `overrun` pulses for one cycle. That byte and the rest of the frame up to its end marker are not written. No descriptor changes, and the ring position does not move.
- R9: Asserting `sw_clr` clears the used bit of entry `sw_clr_idx`. Software reads of word 0 and word 1 are registered, with one cycle of latency.
- R10: Bytes that arrive outside a frame are ignored. A start marker inside a frame restarts writing at offset 0 of the current entry, without consuming an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| sw_idx | input | IW | Descriptor index to read |
| sw_clr | input | 1 | Clear the used bit of `sw_clr_idx` |
| sw_clr_idx | input | IW | Entry whose used bit is cleared |
| sw_word0 | output | 32 | Word 0 of entry `sw_idx`, one cycle later |
| sw_word1 | output | 32 | Word 1 of entry `sw_idx`, one cycle later |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | IW+7 | Buffer byte address |
| buf_data | output | 8 | Buffer byte |
| overrun | output | 1 | One-cycle pulse when a frame is dropped for lack of a free buffer |

## Verification
A wrong offset or ring position shows up at once on the write port: the very next written byte carries a wrong `buf_addr`. A late or missing wrap shows up in the first byte after offset 127. A wrong used bit shows up in two ways. Four cycles after a frame ends, it appears as a wrong bit 0 in a descriptor read. Or, the next time that entry comes around, an overrun appears or fails to appear. A status error stays invisible until that entry is read back, so the bench reads descriptors after every scenario and also compares every output against a reference model on every clock.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int BUF_BYTES = 128;
  localparam int OFF_W     = 7;
  localparam int LEN_W     = 12;
  localparam int HDR_BYTES = 6;
  localparam int W1_SOF    = 14;
  localparam int W1_EOF    = 15;
  localparam int W1_BCAST  = 31;

  typedef struct packed {
    logic             bcast;
    logic             eof;
    logic             sof;
    logic [LEN_W-1:0] len;
  } rxr_stat_t;

  function automatic logic [31:0] rxr_pack_w1(rxr_stat_t s);
    logic [31:0] w;
    w              = '0;
    w[LEN_W-1:0]   = s.len;
    w[W1_SOF]      = s.sof;
    w[W1_EOF]      = s.eof;
    w[W1_BCAST]    = s.bcast;
    return w;
  endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int RING = 32,
  localparam int IW  = $clog2(RING)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] head
);
  localparam logic [IW-1:0] LAST = IW'(RING - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
    end else if (adv) begin
      head <= (head == LAST) ? '0 : head + 1'b1;
    end
  end
endmodule

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
  import rxr_pkg::*;
#(
  parameter int RING = 32,
  localparam int IW  = $clog2(RING)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_we,
  input  logic [IW-1:0] st_idx,
  input  logic [31:0]   st_word,
  input  logic          set_we,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_we,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] head_idx,
  output logic          head_used,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_w0,
  output logic [31:0]   rd_w1
);
  logic [31:0]     stat_mem [RING];
  logic [RING-1:0] used;
  logic [31:0]     mem_q;
  logic [31:0]     w0_n;

  initial begin
    for (int i = 0; i < RING; i++) stat_mem[i] = '0;
  end

  // status memory: one write port, one registered read port (read-first)
  always_ff @(posedge clk) begin
    if (st_we) stat_mem[st_idx] <= st_word;
    mem_q <= stat_mem[rd_idx];
  end

  // ownership flags: the hardware set wins over a software clear of the same entry
  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0;
    end else begin
      if (clr_we) used[clr_idx] <= 1'b0;
      if (set_we) used[set_idx] <= 1'b1;
    end
  end

  assign head_used = used[head_idx];

  always_comb begin
    w0_n                    = '0;
    w0_n[IW+OFF_W-1:OFF_W]  = rd_idx;
    w0_n[1]                 = (rd_idx == IW'(RING - 1));
    w0_n[0]                 = used[rd_idx];
  end

  logic rd_valid;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_w0    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_w0    <= w0_n;
      rd_valid <= 1'b1;
    end
  end

  assign rd_w1 = rd_valid ? mem_q : '0;
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
  import rxr_pkg::*;
#(
  parameter int RING = 32,
  localparam int IW  = $clog2(RING),
  localparam int AW  = IW + OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [IW-1:0] head,
  input  logic          head_used,
  output logic          adv,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic          overrun,
  output logic          st_we,
  output logic [IW-1:0] st_idx,
  output logic [31:0]   st_word,
  output logic          set_we,
  output logic [IW-1:0] set_idx
);
  logic             in_frame, dropping, sof_buf, bc_ok;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] len;

  logic             start, active, blocked, take, close;
  logic [OFF_W-1:0] cur_off;
  logic [LEN_W-1:0] len_cur, len_nxt;
  logic             sofb_cur, bc_cur, bc_nxt;
  rxr_stat_t        stat_n;

  always_comb begin
    start    = rx_valid & rx_sof;
    active   = rx_valid & (start | (in_frame & ~dropping));
    cur_off  = start ? '0 : off;
    len_cur  = start ? '0 : len;
    sofb_cur = start | sof_buf;
    bc_cur   = start | bc_ok;
    blocked  = active & (cur_off == '0) & head_used;
    take     = active & ~blocked;
    close    = take & (rx_eof | (cur_off == OFF_W'(BUF_BYTES - 1)));
    len_nxt  = len_cur + 1'b1;
    bc_nxt   = bc_cur & ~((len_cur < LEN_W'(HDR_BYTES)) & (rx_data != 8'hFF));
    stat_n.sof   = sofb_cur;
    stat_n.eof   = rx_eof;
    stat_n.len   = rx_eof ? len_nxt : '0;
    stat_n.bcast = rx_eof & bc_nxt & (len_nxt >= LEN_W'(HDR_BYTES));
  end

  assign adv = close;

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
      overrun  <= 1'b0;
      st_we    <= 1'b0;
      st_idx   <= '0;
      st_word  <= '0;
      set_we   <= 1'b0;
      set_idx  <= '0;
    end else begin
      buf_we   <= take;
      buf_addr <= {head, cur_off};
      buf_data <= rx_data;
      overrun  <= blocked;
      st_we    <= close;
      st_idx   <= head;
      st_word  <= rxr_pack_w1(stat_n);
      set_we   <= st_we;
      set_idx  <= st_idx;
    end
  end

  // frame state
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      dropping <= 1'b0;
      sof_buf  <= 1'b0;
      bc_ok    <= 1'b0;
      off      <= '0;
      len      <= '0;
    end else if (rx_valid) begin
      if (start | in_frame) begin
        in_frame <= ~rx_eof;
        dropping <= rx_eof ? 1'b0 : ((dropping & ~start) | blocked);
      end
      if (take) begin
        off     <= close ? '0 : cur_off + 1'b1;
        len     <= len_nxt;
        sof_buf <= close ? 1'b0 : sofb_cur;
        bc_ok   <= bc_nxt;
      end
    end
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int RING = 32,
  localparam int IW  = $clog2(RING),
  localparam int AW  = IW + OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [IW-1:0] sw_idx,
  input  logic          sw_clr,
  input  logic [IW-1:0] sw_clr_idx,
  output logic [31:0]   sw_word0,
  output logic [31:0]   sw_word1,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic          overrun
);
  logic          adv, head_used, st_we, set_we;
  logic [IW-1:0] head, st_idx, set_idx;
  logic [31:0]   st_word;

  rxr_ring_ptr #(.RING(RING)) u_ptr (
    .clk(clk), .rst(rst), .adv(adv), .head(head)
  );

  rxr_fill #(.RING(RING)) u_fill (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .head(head), .head_used(head_used), .adv(adv),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .overrun(overrun),
    .st_we(st_we), .st_idx(st_idx), .st_word(st_word),
    .set_we(set_we), .set_idx(set_idx)
  );

  rxr_desc_store #(.RING(RING)) u_store (
    .clk(clk), .rst(rst),
    .st_we(st_we), .st_idx(st_idx), .st_word(st_word),
    .set_we(set_we), .set_idx(set_idx),
    .clr_we(sw_clr), .clr_idx(sw_clr_idx),
    .head_idx(head), .head_used(head_used),
    .rd_idx(sw_idx), .rd_w0(sw_word0), .rd_w1(sw_word1)
  );
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
  parameter int RING = 32,
  localparam int IW  = $clog2(RING),
  localparam int AW  = IW + 7
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] sw_idx,
  input logic [31:0]   sw_word0,
  input logic [31:0]   sw_word1,
  input logic          buf_we,
  input logic [AW-1:0] buf_addr,
  input logic          overrun
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!buf_we && !overrun));

  // R8
  ovr_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !buf_we);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we) && !$past(rst) && ($past(buf_addr[6:0]) != 7'd127)
     && (buf_addr[6:0] != 7'd0)) |-> (buf_addr == $past(buf_addr) + 1'b1));

  // R4
  addr_field_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sw_word0[IW+6:7] == $past(sw_idx)));

  // R4
  wrap_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sw_word0[1] == ($past(sw_idx) == IW'(RING - 1))));

  // R5
  used_after_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(sw_idx) == $past(sw_idx, 2))
     && $rose(sw_word0[0])) |-> $stable(sw_word1));
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.RING(RING)) u_chk (
  .clk(clk), .rst(rst), .sw_idx(sw_idx), .sw_word0(sw_word0), .sw_word1(sw_word1),
  .buf_we(buf_we), .buf_addr(buf_addr), .overrun(overrun)
);

// File: tb/tb_rxr_ring_writer.sv
module tb_rxr_ring_writer;
  localparam int RING = 32;
  localparam int IW   = $clog2(RING);
  localparam int AW   = IW + 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]    rx_data = '0;
  logic [IW-1:0] sw_idx = '0, sw_clr_idx = '0;
  logic          sw_clr = 1'b0;
  logic [31:0]   sw_word0, sw_word1;
  logic          buf_we, overrun;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_data;

  int tests = 0, fails = 0, ovr_cnt = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  rxr_ring_writer #(.RING(RING)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .sw_idx(sw_idx), .sw_clr(sw_clr),
    .sw_clr_idx(sw_clr_idx), .sw_word0(sw_word0), .sw_word1(sw_word1),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .overrun(overrun)
  );

  // behavioural reference model
  bit          m_used [RING];
  logic [31:0] m_stat [RING];
  int          m_head, m_off, m_len;
  bit          m_inf, m_drop, m_sofb, m_bc;
  bit          ps_v, pu_v;
  int          ps_i, pu_i;
  logic [31:0] ps_w;
  logic        e_we, e_ovr;
  int          e_addr;
  logic [7:0]  e_data;
  logic [31:0] e_w0, e_w1;

  initial for (int i = 0; i < RING; i++) begin m_used[i] = 0; m_stat[i] = '0; end

  always @(posedge clk) begin
    bit hu;
    int k;
    if (rst) begin
      for (int i = 0; i < RING; i++) m_used[i] = 0;
      m_head = 0; m_off = 0; m_len = 0; m_inf = 0; m_drop = 0; m_sofb = 0; m_bc = 0;
      ps_v = 0; pu_v = 0; e_we = 0; e_ovr = 0; e_w0 = '0; e_w1 = '0;
    end else begin
      k = int'(sw_idx);
      e_w0 = 32'(k * 128) | ((k == RING - 1) ? 32'h2 : 32'h0) | 32'(m_used[k]);
      e_w1 = m_stat[k];
      hu = m_used[m_head];
      if (sw_clr) m_used[int'(sw_clr_idx)] = 0;
      if (pu_v) m_used[pu_i] = 1;
      if (ps_v) m_stat[ps_i] = ps_w;
      pu_v = ps_v; pu_i = ps_i; ps_v = 0;
      e_we = 0; e_ovr = 0;
      if (rx_valid && (rx_sof || m_inf)) begin
        if (rx_sof) begin m_drop = 0; m_off = 0; m_len = 0; m_sofb = 1; m_bc = 1; end
        if (!m_drop) begin
          if (m_off == 0 && hu) begin
            e_ovr = 1; m_drop = 1;
          end else begin
            e_we = 1; e_addr = m_head * 128 + m_off; e_data = rx_data;
            if (m_len < 6 && rx_data != 8'hFF) m_bc = 0;
            m_len = (m_len + 1) % 4096;
            m_off++;
            if (rx_eof || m_off == 128) begin
              ps_v = 1; ps_i = m_head;
              ps_w = (32'(m_sofb) << 14) | (32'(rx_eof) << 15)
                   | (rx_eof ? 32'(m_len) : 32'h0)
                   | (32'(rx_eof && m_bc && m_len >= 6) << 31);
              m_head = (m_head + 1) % RING; m_off = 0; m_sofb = 0;
            end
          end
        end
        m_inf = !rx_eof;
        if (rx_eof) m_drop = 0;
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      tests++;
      if (buf_we !== e_we || (e_we && (buf_addr !== AW'(e_addr) || buf_data !== e_data))) begin
        fails++;
        $display("FAIL R2 write port: we=%0b addr=%0h data=%0h expected we=%0b addr=%0h data=%0h",
                 buf_we, buf_addr, buf_data, e_we, e_addr, e_data);
      end
      tests++;
      if (overrun !== e_ovr) begin
        fails++;
        $display("FAIL R8 overrun: %0b expected %0b", overrun, e_ovr);
      end
      tests++;
      if (sw_word0 !== e_w0) begin
        fails++;
        $display("FAIL R4 word0: %h expected %h", sw_word0, e_w0);
      end
      tests++;
      if (sw_word1 !== e_w1) begin
        fails++;
        $display("FAIL R6 word1: %h expected %h", sw_word1, e_w1);
      end
      if (overrun === 1'b1) ovr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input int n, input bit bc, input int seed, input bit last = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = last && (i == n - 1);
      rx_data = (bc && i < 6) ? 8'hFF : 8'((seed + i * 3) & 8'h7F);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic idle_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_eof = 0; rx_data = 8'(i + 1);
    end
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] w0, output logic [31:0] w1);
    repeat (4) @(negedge clk);
    sw_idx = IW'(idx);
    @(negedge clk);
    w0 = sw_word0; w1 = sw_word1;
  endtask

  task automatic clr(input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk); sw_clr = 1; sw_clr_idx = IW'(i);
    end
    @(negedge clk); sw_clr = 0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] w0, w1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 buf_we", 32'(buf_we), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 word0", sw_word0, 0);
    chk("R1 word1", sw_word1, 0);
    rst = 0;
    started = 1;
    rd(5, w0, w1);
    chk("R1 entry5 used clear", w0, 32'h280);

    // R6 R7: 300-byte broadcast frame across entries 0..2
    send(300, 1, 10);
    rd(0, w0, w1); chk("R6 entry0 start", w1, 32'h4000); chk("R4 entry0 used", w0, 32'h1);
    rd(1, w0, w1); chk("R6 entry1 middle", w1, 32'h0);
    rd(2, w0, w1); chk("R7 entry2 end bcast", w1, 32'h8000812C); chk("R4 entry2", w0, 32'h101);
    rd(3, w0, w1); chk("R3 entry3 untouched", w0, 32'h180);

    // R9: software returns entries 0..2
    clr(0, 2);
    rd(0, w0, w1); chk("R9 entry0 cleared", w0, 32'h0);

    // R6: short non-broadcast frame at entry 3
    send(10, 0, 1);
    rd(3, w0, w1); chk("R6 entry3 short", w1, 32'h0000C00A); chk("R5 entry3 used", w0, 32'h181);

    // R10: stray bytes, then a frame restarted by a second start marker
    idle_bytes(5);
    send(5, 0, 2, 0);
    send(3, 0, 3);
    rd(4, w0, w1); chk("R10 restart entry4", w1, 32'h0000C003);
    rd(5, w0, w1); chk("R10 entry5 not consumed", w0, 32'h280);

    // R7 boundaries: six 0xFF bytes vs. five
    send(6, 1, 0);
    send(5, 1, 0);
    rd(5, w0, w1); chk("R7 six-byte broadcast", w1, 32'h8000C006);
    rd(6, w0, w1); chk("R7 five-byte not broadcast", w1, 32'h0000C005);

    // R3: exact 128-byte frames move the ring to entry 30
    for (int f = 0; f < 23; f++) send(128, 0, f);
    rd(7, w0, w1); chk("R3 full-buffer frame", w1, 32'h0000C080);

    // R3 wrap: frame spanning entries 30, 31, 0
    clr(0, RING - 1);
    send(300, 0, 5);
    rd(30, w0, w1); chk("R3 wrap entry30", w1, 32'h4000);
    rd(31, w0, w1); chk("R4 entry31 wrap flag", w0, 32'hF83); chk("R6 entry31 middle", w1, 32'h0);
    rd(0, w0, w1); chk("R3 wrapped end entry0", w1, 32'h0000812C);

    // R8: fill entries 1..29, then entry 30 is still owned by software
    for (int f = 0; f < 29; f++) send(1, 0, f);
    rd(29, w0, w1); chk("R6 one-byte frame", w1, 32'h0000C001);
    send(20, 0, 9);
    rd(30, w0, w1);
    chk("R8 overrun at frame start", 32'(ovr_cnt), 1);
    chk("R8 entry30 status kept", w1, 32'h4000);

    // R8: mid-frame overrun when entry 31 is still owned
    clr(30, 30);
    send(200, 0, 4);
    rd(31, w0, w1);
    chk("R8 overrun mid frame", 32'(ovr_cnt), 2);
    chk("R8 entry31 status kept", w1, 32'h0);
    rd(30, w0, w1); chk("R8 entry30 filled", w0, 32'hF01);

    // R9 then R3: freed entry 31 takes the next frame
    clr(31, 31);
    rd(31, w0, w1); chk("R9 entry31 cleared", w0, 32'hF82);
    send(4, 0, 6);
    rd(31, w0, w1); chk("R3 entry31 frame", w1, 32'h0000C004); chk("R5 entry31 used", w0, 32'hF83);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule